// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM from power-on to a usable state. After reset it holds the clock enable low while supply and clock settle. It then raises the clock enable, idles with NOPs, and plays a fixed run of commands on the command pins. Each command is followed by the wait the memory needs before the next one. The run is: close all banks, program the extended mode register with the DLL on, program the mode register with the DLL reset bit set, close all banks again, refresh twice, and program the mode register again with the DLL reset bit clear.

The DLL lock window starts at the DLL-reset command and runs alongside the later steps. The ready flag rises only when the final mode-register wait and the lock window have both elapsed. A controller sits behind the block and asks to start traffic through a request line. Requests are refused, with no grant, until initialization has finished. A refused requester keeps its request raised and retries; nothing is queued.

Every wait length, the address-bus width, the bank-address width, the bit that selects all banks on a precharge, the DLL-reset bit and the mode fields are parameters. All pin outputs come from flops.

Top module: `dram_powerup_seq`

## Requirements
- R1: While reset is asserted (asynchronous, active low), cke_o is 0, the pins show deselect ({cs_n,ras_n,cas_n,we_n}=1111), ba_o and addr_o are 0, init_done_o is 0 and req_grant_o is 0.
- R2: After reset is released, cke_o stays 0 with deselect for STABLE_CYC cycles. It then goes to 1, and NOP (0111) is driven for NOP_CYC cycles before the first command. cs_n_o is never 0 while cke_o is 0.
- R3: Exactly seven commands are issued, in this order: precharge-all, extended mode set, mode set with DLL reset, precharge-all, refresh, refresh, mode set without DLL reset. The encodings are precharge 0010 with addr bit AP_BIT set and all other address bits 0, refresh 0001 with address 0, and mode set 0000.
- R4: The extended mode set uses ba_o=1 (high bank bit 0, low bank bit 1). Its addr bit 0 is 0 (DLL on), addr bit 1 equals DRV_WEAK, and all other address bits are 0.
- R5: Both mode sets use ba_o=0. Their addr carries burst length code BL_CODE in bits 2:0, burst type BT_INTLV in bit 3 and latency code CL_CODE in bits 6:4. Bit DLL_RST_BIT is 1 on the first mode set and 0 on the second.
- R6: The distance from one command to the next is TRP_CYC after a precharge, TMRD_CYC after a mode set and TRFC_CYC after a refresh. Between commands the pins show NOP with cke_o at 1.
- R7: init_done_o first rises max(2*TMRD_CYC+TRP_CYC+2*TRFC_CYC, LOCK_CYC) cycles after the DLL-reset mode set. It then stays 1, with NOP and no further command.
- R8: req_grant_o is 1 exactly when req_valid_i is 1 and init_done_o is 1. Requests before that are refused.
- R9: A reset applied at any point of the run returns the pins to the R1 state at once, and the full sequence restarts from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands launch on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Controller asks to begin normal traffic |
| req_grant_o | output | 1 | Request accepted (only after initialization) |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address / mode-register target |
| addr_o | output | ADDR_W | Address bus / mode-register contents |
| init_done_o | output | 1 | Initialization complete |

## Verification
Assertions check several rules on every cycle. Chip select stays off while the clock enable is low. A precharge always carries the all-banks bit. A mode set never targets a high bank group. No command follows a mode set sooner than the mode-set wait. The ready flag is never raised before the lock window has elapsed, and once raised it stays high with quiet pins. Other properties need the bench's scenarios: the exact command order, the address contents of each mode set, the exact gaps, the cycle at which the ready flag rises, and the restart after a reset at a random point.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [3:0] {
    ST_CKE_LOW,
    ST_NOP_WAIT,
    ST_PREA_1,
    ST_EMRS,
    ST_MRS_RST,
    ST_PREA_2,
    ST_REF_1,
    ST_REF_2,
    ST_MRS_FIN,
    ST_DONE
  } step_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] pin_cmd_t;

  localparam pin_cmd_t PIN_DESEL = 4'b1111;
  localparam pin_cmd_t PIN_NOP   = 4'b0111;
  localparam pin_cmd_t PIN_PREA  = 4'b0010;
  localparam pin_cmd_t PIN_REF   = 4'b0001;
  localparam pin_cmd_t PIN_MRS   = 4'b0000;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_real_cmd(input pin_cmd_t c);
    return (c[3] == 1'b0) && (c != PIN_NOP);
  endfunction

  function automatic step_t next_step(input step_t s);
    case (s)
      ST_CKE_LOW:  return ST_NOP_WAIT;
      ST_NOP_WAIT: return ST_PREA_1;
      ST_PREA_1:   return ST_EMRS;
      ST_EMRS:     return ST_MRS_RST;
      ST_MRS_RST:  return ST_PREA_2;
      ST_PREA_2:   return ST_REF_1;
      ST_REF_1:    return ST_REF_2;
      ST_REF_2:    return ST_MRS_FIN;
      default:     return ST_DONE;
    endcase
  endfunction

endpackage

// File: rtl/init_step_timer.sv
module init_step_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (restart_i)     cnt_o <= '0;
    else if (cnt_o != CNT_TOP) cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/dll_lock_timer.sv
module dll_lock_timer #(
  parameter int unsigned LOCK_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic lock_near_o,
  output logic lock_done_o
);

  localparam int unsigned LK_W = $clog2(LOCK_CYC + 1);
  localparam logic [LK_W-1:0] LK_END = LK_W'(LOCK_CYC);

  logic [LK_W-1:0] lk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lk_q <= '0;
    else if (start_i)                     lk_q <= LK_W'(1);
    else if (lk_q != '0 && lk_q != LK_END) lk_q <= lk_q + 1'b1;
  end

  // lk_q equals the number of cycles since the start pulse, saturated
  assign lock_near_o = (lk_q >= LK_END - 1'b1);
  assign lock_done_o = (lk_q == LK_END);

  p_lock_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_done_o && !start_i) |=> lock_done_o);

endmodule

// File: rtl/init_pin_driver.sv
module init_pin_driver
  import dram_init_pkg::*;
#(
  parameter int unsigned BA_W     = 2,
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned AP_BIT   = 10,
  parameter int unsigned TMRD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_d,
  input  pin_cmd_t          cmd_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              done_d,
  output logic              cke_o,
  output pin_cmd_t          cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o  <= 1'b0;
      cmd_o  <= PIN_DESEL;
      ba_o   <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      cke_o  <= cke_d;
      cmd_o  <= cmd_d;
      ba_o   <= ba_d;
      addr_o <= addr_d;
      done_o <= done_d;
    end
  end

  // Spacing monitor: cycles since the last command on the pins
  localparam int unsigned GAP_W = $clog2(TMRD_CYC + 2);
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(TMRD_CYC);
  logic [GAP_W-1:0] gap_q;
  logic             mode_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '0;
      mode_last_q <= 1'b0;
    end else if (is_real_cmd(cmd_o)) begin
      gap_q       <= GAP_W'(1);
      mode_last_q <= (cmd_o == PIN_MRS);
    end else if (gap_q != GAP_SAT) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_cke_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cmd_o[3]);

  p_prea_allbanks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == PIN_PREA) |-> addr_o[AP_BIT]);

  p_mode_target_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == PIN_MRS) |-> (ba_o[BA_W-1:1] == '0));

  p_mode_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_real_cmd(cmd_o) && mode_last_q) |-> (gap_q >= GAP_SAT));

  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cke_o && cmd_o == PIN_NOP));

endmodule

// File: rtl/dram_powerup_seq.sv
module dram_powerup_seq
  import dram_init_pkg::*;
#(
  parameter int unsigned BA_W        = 2,
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned AP_BIT      = 10,
  parameter int unsigned DLL_RST_BIT = 8,
  parameter int unsigned STABLE_CYC  = 20,
  parameter int unsigned NOP_CYC     = 4,
  parameter int unsigned TRP_CYC     = 3,
  parameter int unsigned TMRD_CYC    = 2,
  parameter int unsigned TRFC_CYC    = 10,
  parameter int unsigned LOCK_CYC    = 200,
  parameter logic [2:0]  CL_CODE     = 3'b011,
  parameter logic        BT_INTLV    = 1'b0,
  parameter logic [2:0]  BL_CODE     = 3'b010,
  parameter logic        DRV_WEAK    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_grant_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);

  localparam int unsigned MAX_LEN =
    max2(max2(max2(STABLE_CYC, NOP_CYC), max2(TRP_CYC, TMRD_CYC)), TRFC_CYC);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  localparam logic [ADDR_W-1:0] ADDR_PREA = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] ADDR_EMRS = ADDR_W'(DRV_WEAK) << 1;
  localparam logic [ADDR_W-1:0] ADDR_MODE =
    (ADDR_W'(CL_CODE) << 4) | (ADDR_W'(BT_INTLV) << 3) | ADDR_W'(BL_CODE);
  localparam logic [ADDR_W-1:0] ADDR_MODE_RST = ADDR_MODE | (ADDR_W'(1) << DLL_RST_BIT);
  localparam logic [BA_W-1:0]   BA_MODE = '0;
  localparam logic [BA_W-1:0]   BA_EXT  = BA_W'(1);

  step_t            st_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] step_len;
  logic             advance;
  logic             at_cmd;
  logic             lock_start, lock_near, lock_done;

  logic              cke_d, done_d;
  pin_cmd_t          cmd_d, cmd_q;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  init_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (advance),
    .cnt_o     (cnt)
  );

  dll_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (lock_start),
    .lock_near_o (lock_near),
    .lock_done_o (lock_done)
  );

  always_comb begin
    case (st_q)
      ST_CKE_LOW:  step_len = CNT_W'(STABLE_CYC);
      ST_NOP_WAIT: step_len = CNT_W'(NOP_CYC);
      ST_PREA_1,
      ST_PREA_2:   step_len = CNT_W'(TRP_CYC);
      ST_REF_1,
      ST_REF_2:    step_len = CNT_W'(TRFC_CYC);
      ST_EMRS,
      ST_MRS_RST,
      ST_MRS_FIN:  step_len = CNT_W'(TMRD_CYC);
      default:     step_len = CNT_W'(1);
    endcase
  end

  assign at_cmd     = (cnt == '0);
  assign lock_start = (st_q == ST_MRS_RST) && at_cmd;

  always_comb begin
    case (st_q)
      ST_DONE:    advance = 1'b0;
      ST_MRS_FIN: advance = (cnt >= step_len - 1'b1) && lock_near;
      default:    advance = (cnt == step_len - 1'b1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= ST_CKE_LOW;
    else if (advance) st_q <= next_step(st_q);
  end

  always_comb begin
    cke_d  = 1'b1;
    cmd_d  = PIN_NOP;
    ba_d   = '0;
    addr_d = '0;
    done_d = 1'b0;
    case (st_q)
      ST_CKE_LOW: begin
        cke_d = 1'b0;
        cmd_d = PIN_DESEL;
      end
      ST_PREA_1, ST_PREA_2: if (at_cmd) begin
        cmd_d  = PIN_PREA;
        addr_d = ADDR_PREA;
      end
      ST_EMRS: if (at_cmd) begin
        cmd_d  = PIN_MRS;
        ba_d   = BA_EXT;
        addr_d = ADDR_EMRS;
      end
      ST_MRS_RST: if (at_cmd) begin
        cmd_d  = PIN_MRS;
        ba_d   = BA_MODE;
        addr_d = ADDR_MODE_RST;
      end
      ST_MRS_FIN: if (at_cmd) begin
        cmd_d  = PIN_MRS;
        ba_d   = BA_MODE;
        addr_d = ADDR_MODE;
      end
      ST_REF_1, ST_REF_2: if (at_cmd) cmd_d = PIN_REF;
      ST_DONE: done_d = lock_done;
      default: ;
    endcase
  end

  init_pin_driver #(
    .BA_W     (BA_W),
    .ADDR_W   (ADDR_W),
    .AP_BIT   (AP_BIT),
    .TMRD_CYC (TMRD_CYC)
  ) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_d  (cke_d),
    .cmd_d  (cmd_d),
    .ba_d   (ba_d),
    .addr_d (addr_d),
    .done_d (done_d),
    .cke_o  (cke_o),
    .cmd_o  (cmd_q),
    .ba_o   (ba_o),
    .addr_o (addr_o),
    .done_o (init_done_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign req_grant_o = req_valid_i && init_done_o;

  p_done_after_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> lock_done);

  p_grant_after_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_grant_o |-> lock_done);

  p_lock_before_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MRS_FIN && !lock_near) |=> (st_q == ST_MRS_FIN));

endmodule

// File: tb/dram_powerup_seq_test.sv
module dram_powerup_seq_test;

  localparam int CLK_P    = 8;
  localparam int BA_W     = 2;
  localparam int ADDR_W   = 13;
  localparam int AP_BIT   = 10;
  localparam int DLLR_BIT = 8;
  localparam int STABLE   = 20;
  localparam int NOPC     = 4;
  localparam int TRP      = 3;
  localparam int TMRD     = 2;
  localparam int TRFC     = 10;
  localparam int LOCK     = 200;
  localparam logic [2:0] CL = 3'b011;
  localparam logic       BT = 1'b0;
  localparam logic [2:0] BL = 3'b010;
  localparam logic       DW = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_grant, cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;

  always #(CLK_P/2) clk = ~clk;

  dram_powerup_seq #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .DLL_RST_BIT(DLLR_BIT),
    .STABLE_CYC(STABLE), .NOP_CYC(NOPC), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
    .TRFC_CYC(TRFC), .LOCK_CYC(LOCK), .CL_CODE(CL), .BT_INTLV(BT),
    .BL_CODE(BL), .DRV_WEAK(DW)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_grant_o(req_grant),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .init_done_o(done)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected command stream, computed from the requirements
  function automatic logic [3:0] exp_cmd(input int i);
    case (i)
      0, 3:    return 4'b0010;
      4, 5:    return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int exp_ba(input int i);
    return (i == 1) ? 1 : 0;
  endfunction

  function automatic int exp_addr(input int i);
    int mode;
    mode = (int'(CL) << 4) | (int'(BT) << 3) | int'(BL);
    case (i)
      0, 3:    return 1 << AP_BIT;
      1:       return int'(DW) << 1;
      2:       return mode | (1 << DLLR_BIT);
      6:       return mode;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_gap(input int i);
    case (i)
      0, 3:    return TRP;
      4, 5:    return TRFC;
      default: return TMRD;
    endcase
  endfunction

  function automatic int exp_done_delay();
    int t;
    t = 2 * TMRD + TRP + 2 * TRFC;
    return (t > LOCK) ? t : LOCK;
  endfunction

  // monitor state
  bit mon_on = 1'b0;
  int n, nlog, cke_idx, done_idx, bad_idle, bad_grant, post_cmds;
  bit seen_cke, seen_done;
  logic [3:0]        lg_cmd  [16];
  int                lg_n    [16];
  int                lg_ba   [16];
  int                lg_addr [16];

  always @(negedge clk) begin
    if (mon_on) begin
      logic [3:0] c;
      n++;
      c = {cs_n, ras_n, cas_n, we_n};
      if (cke && !seen_cke) begin seen_cke = 1'b1; cke_idx = n; end
      if (done && !seen_done) begin seen_done = 1'b1; done_idx = n; end
      if (!cke && !cs_n) bad_idle++;
      if (c != 4'b0111 && c != 4'b1111) begin
        if (nlog < 16) begin
          lg_cmd[nlog] = c; lg_n[nlog] = n; lg_ba[nlog] = int'(ba); lg_addr[nlog] = int'(addr);
        end
        nlog++;
        if (seen_done) post_cmds++;
      end else if (cke && c != 4'b0111) begin
        bad_idle++;
      end
      if (req_grant !== (req_valid && done)) bad_grant++;
      req_valid = 1'($urandom_range(0, 1));
    end
  end

  task automatic check_reset_state(input string tag);
    chk(cke == 1'b0, "R1", {tag, " cke"}, cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", {tag, " pins deselect"},
        {cs_n, ras_n, cas_n, we_n}, 15);
    chk(ba == '0 && addr == '0, "R1", {tag, " ba/addr"}, addr, 0);
    chk(done == 1'b0 && req_grant == 1'b0, "R1", {tag, " done/grant"}, done, 0);
  endtask

  task automatic run_init();
    int guard;
    n = 0; nlog = 0; cke_idx = -1; done_idx = -1;
    bad_idle = 0; bad_grant = 0; post_cmds = 0;
    seen_cke = 1'b0; seen_done = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 mon_on = 1'b1;
    guard = 0;
    while (!seen_done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (25) @(negedge clk);
    #1 mon_on = 1'b0;
    chk(seen_done, "R7", "done reached", seen_done, 1);
  endtask

  task automatic check_sequence();
    chk(cke_idx == STABLE + 1, "R2", "cke rise cycle", cke_idx, STABLE + 1);
    chk(bad_idle == 0, "R2", "idle pins (deselect while cke low, NOP between commands) R6",
        bad_idle, 0);
    chk(nlog == 7, "R3", "command count", nlog, 7);
    if (nlog >= 7) begin
      chk(lg_n[0] == STABLE + 1 + NOPC, "R2", "first command cycle",
          lg_n[0], STABLE + 1 + NOPC);
      for (int i = 0; i < 7; i++) begin
        chk(lg_cmd[i] == exp_cmd(i), "R3", $sformatf("command %0d code", i),
            lg_cmd[i], exp_cmd(i));
        chk(lg_ba[i] == exp_ba(i), (i == 1) ? "R4" : "R5",
            $sformatf("command %0d bank", i), lg_ba[i], exp_ba(i));
        chk(lg_addr[i] == exp_addr(i), (i == 1) ? "R4" : "R5",
            $sformatf("command %0d address", i), lg_addr[i], exp_addr(i));
      end
      for (int i = 0; i < 6; i++)
        chk(lg_n[i+1] - lg_n[i] == exp_gap(i), "R6", $sformatf("gap after command %0d", i),
            lg_n[i+1] - lg_n[i], exp_gap(i));
      chk(done_idx - lg_n[2] == exp_done_delay(), "R7", "done delay from DLL reset",
          done_idx - lg_n[2], exp_done_delay());
    end
    chk(post_cmds == 0, "R7", "no command after done", post_cmds, 0);
    chk(done == 1'b1, "R7", "done held", done, 1);
    chk(bad_grant == 0, "R8", "grant equals valid and done", bad_grant, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 check_reset_state("initial");
    run_init();
    check_sequence();

    // directed: request right at done vs before done
    @(negedge clk);
    req_valid = 1'b1;
    #1 chk(req_grant == 1'b1, "R8", "grant after done", req_grant, 1);

    for (int r = 0; r < 3; r++) begin
      int k;
      k = (r == 0) ? 1 : int'($urandom_range(5, 240));
      @(negedge clk);
      rst_n = 1'b0;
      #1 check_reset_state("reset after done");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (k) @(negedge clk);
      req_valid = 1'b1;
      #1 if (k < STABLE + NOPC + 2 * TMRD + TRP + 2 * TRFC + LOCK / 2)
        chk(req_grant == 1'b0, "R8", $sformatf("refused at cycle %0d", k), req_grant, 0);
      @(negedge clk);
      rst_n = 1'b0;
      #1 check_reset_state($sformatf("R9 mid reset at %0d", k));
      repeat (2) @(negedge clk);
      run_init();
      check_sequence();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule